// File: doc/BRIEF.md
# Prescaled Interval Timer

An 8-bit interval timer that counts down at one of four programmable rates: once every 1, 8, 64 or 1024 enabled clocks. Software starts it by writing a start value. The address bits of that write carry the rate and the timer interrupt enable, so the data byte holds only the count. Software can read the live count and a small flag register at any time. Once the count passes through zero, the timer raises a timeout flag and then counts once per enabled clock. This lets software find out how long ago the interval expired. An active-low interrupt request combines the timeout (when enabled) with an edge-event flag that an external port-pin edge detector supplies.

The block sits behind an address decoder that already resolves chip and RAM selection. A single `reg_sel` strobe marks a register access in the clock cycle it is high. Accesses are single-cycle, need no handshake and never stall. Read data is combinational from current state and valid in the strobe cycle. `clk_en` gates only the counting, and register accesses act whether or not it is high. There is no streamed data path, so no valid/ready interface applies.

Top module: `intv_timer`

## Requirements
- R1: After reset the count is 0, the timeout flag is 0, the timer interrupt enable is 0 and the timer prescale is divide-by-1; with `edge_flag` low, `irq_n` is high.
- R2: A write (`reg_sel`=1, `rd_wr`=0) with addr[4]=1 and addr[2]=1 loads `wdata` into the count on that clock edge and clears the timeout flag.
- R3: On that write, addr[1:0] selects the prescale: 00 divides by 1, 01 by 8, 10 by 64, 11 by 1024. The first decrement lands on the N-th enabled clock edge after the load, and later decrements land every N enabled clocks.
- R4: On a timer write, addr[3]=1 enables the timer interrupt and addr[3]=0 disables it.
- R5: A read (`rd_wr`=1) with addr[2]=1 and addr[0]=0 returns the count on `rdata` in the same cycle. It also sets the interrupt enable from addr[3], clears the timeout flag, holds the count for that cycle and restarts the programmed prescale period.
- R6: A read with addr[2]=1 and addr[0]=1 returns the timeout flag in bit 7 and `edge_flag` in bit 6, with bits 5..0 zero. This read does not change the flag.
- R7: When a decrement takes the count from 0 to 255, the timeout flag is set. While the flag stays set, the count decrements on every enabled clock.
- R8: `irq_n` is low exactly when (timeout flag AND interrupt enable) OR `edge_flag`.
- R9: While `clk_en` is low, the count and the prescale phase do not advance.
- R10: Accesses that match no decode have no effect on count, flag or enable, and read as 0. These are: `reg_sel` low, addr[2]=0, or a write with addr[4]=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Count enable; the timer advances only when high |
| reg_sel | input | 1 | Decoded register access strobe |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr | input | 5 | Register address bits 4..0 |
| wdata | input | 8 | Write data (timer start value) |
| edge_flag | input | 1 | Edge-event flag from the port-pin edge detector |
| rdata | output | 8 | Read data, valid in the strobe cycle |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The embedded properties check every cycle that a load takes the written value and clears the flag, and that the count holds unless a prescale tick or an access occurs. They also check that a zero pass sets the flag, that the count decrements once per enabled clock after timeout, that the enable is clear out of reset, and that a flag read leaves the flag alone. The bench must show the actual spacing of decrements for each divide ratio, because it depends on a long window of enabled clocks. It must also show that a count read restarts the prescale, and the combined interrupt output under mixed access sequences. A behavioural model checks these against the read data and `irq_n` on every clock, across directed and randomized traffic.

// File: rtl/intv_timer_pkg.sv
package intv_timer_pkg;

  localparam int ADDR_W = 5;
  localparam int PRE_W  = 10;

  typedef enum logic [1:0] {
    DIV_1    = 2'b00,
    DIV_8    = 2'b01,
    DIV_64   = 2'b10,
    DIV_1024 = 2'b11
  } div_sel_e;

  typedef struct packed {
    logic     wr_tmr;
    logic     rd_tmr;
    logic     rd_flg;
    div_sel_e div;
    logic     ie;
  } acc_t;

  // reload value of the prescale down-counter: divide ratio minus one
  function automatic logic [PRE_W-1:0] div_reload(input div_sel_e d);
    logic [PRE_W-1:0] r;
    case (d)
      DIV_1:   r = PRE_W'(0);
      DIV_8:   r = PRE_W'(7);
      DIV_64:  r = PRE_W'(63);
      default: r = PRE_W'(1023);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/intv_decode.sv
module intv_decode
  import intv_timer_pkg::*;
(
  input  logic              sel_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  output acc_t              acc_o
);

  always_comb begin
    acc_o        = '0;
    acc_o.wr_tmr = sel_i & ~rd_i & addr_i[4] & addr_i[2];
    acc_o.rd_tmr = sel_i &  rd_i & addr_i[2] & ~addr_i[0];
    acc_o.rd_flg = sel_i &  rd_i & addr_i[2] &  addr_i[0];
    acc_o.div    = div_sel_e'(addr_i[1:0]);
    acc_o.ie     = addr_i[3];
  end

endmodule

// File: rtl/intv_prescale.sv
module intv_prescale
  import intv_timer_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clk_en_i,
  input  logic     fast_i,
  input  logic     wr_i,
  input  logic     rd_i,
  input  div_sel_e div_i,
  output logic     tick_o
);

  div_sel_e         div_q;
  logic [PRE_W-1:0] pre_q;

  assign tick_o = clk_en_i & ~wr_i & ~rd_i & (fast_i | (pre_q == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= DIV_1;
      pre_q <= '0;
    end else if (wr_i) begin
      div_q <= div_i;
      pre_q <= div_reload(div_i);
    end else if (rd_i) begin
      pre_q <= div_reload(div_q);
    end else if (clk_en_i && !fast_i) begin
      if (pre_q == '0) pre_q <= div_reload(div_q);
      else             pre_q <= pre_q - 1'b1;
    end
  end

  // R9
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_i && !wr_i && !rd_i) |=> $stable(pre_q));

endmodule

// File: rtl/intv_count.sv
module intv_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (wr_i) begin
      cnt_q  <= wdata_i;
      flag_q <= 1'b0;
    end else if (rd_i) begin
      flag_q <= 1'b0;
    end else if (tick_i) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == '0) flag_q <= 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;

  // R2
  load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (cnt_q == $past(wdata_i)) && !flag_q);

  // R5
  read_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !wr_i) |=> $stable(cnt_q) && !flag_q);

endmodule

// File: rtl/intv_timer.sv
module intv_timer
  import intv_timer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              reg_sel,
  input  logic              rd_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              edge_flag,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_n
);

  localparam int FLAG_BIT = DATA_W - 1;
  localparam int EDGE_BIT = DATA_W - 2;

  acc_t              acc;
  logic              pre_tick;
  logic [DATA_W-1:0] cnt;
  logic              tflag;
  logic              ie_q;

  intv_decode u_dec (
    .sel_i  (reg_sel),
    .rd_i   (rd_wr),
    .addr_i (addr),
    .acc_o  (acc)
  );

  intv_prescale u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en_i (clk_en),
    .fast_i   (tflag),
    .wr_i     (acc.wr_tmr),
    .rd_i     (acc.rd_tmr),
    .div_i    (acc.div),
    .tick_o   (pre_tick)
  );

  intv_count #(.CNT_W(DATA_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (pre_tick),
    .wr_i    (acc.wr_tmr),
    .rd_i    (acc.rd_tmr),
    .wdata_i (wdata),
    .cnt_o   (cnt),
    .flag_o  (tflag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        ie_q <= 1'b0;
    else if (acc.wr_tmr || acc.rd_tmr) ie_q <= acc.ie;
  end

  always_comb begin
    rdata = '0;
    if (acc.rd_tmr) begin
      rdata = cnt;
    end else if (acc.rd_flg) begin
      rdata[FLAG_BIT] = tflag;
      rdata[EDGE_BIT] = edge_flag;
    end
  end

  assign irq_n = ~((tflag & ie_q) | edge_flag);

  // R1
  reset_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !ie_q);

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_flag && !ie_q) |-> irq_n);

  // R9
  count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pre_tick && !acc.wr_tmr) |=> $stable(cnt));

  // R7
  zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_tick && cnt == '0) |=> tflag);

  // R7
  fast_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tflag && clk_en && !acc.wr_tmr && !acc.rd_tmr) |=> (cnt == $past(cnt) - 1'b1));

  // R6
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.rd_flg && tflag) |=> tflag);

endmodule

// File: tb/intv_timer_tb.sv
`timescale 1ns/1ps
module intv_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_en = 1'b0;
  logic       reg_sel = 1'b0;
  logic       rd_wr = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       edge_flag = 1'b0;
  logic [7:0] rdata;
  logic       irq_n;

  int vecs  = 0;
  int fails = 0;

  // behavioural reference state
  int m_cnt = 0, m_pre = 0, m_n = 1, m_flag = 0, m_ie = 0;

  always #2.5 clk = ~clk;

  intv_timer dut_i (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .reg_sel(reg_sel),
    .rd_wr(rd_wr), .addr(addr), .wdata(wdata), .edge_flag(edge_flag),
    .rdata(rdata), .irq_n(irq_n)
  );

  function automatic int ratio(input logic [1:0] c);
    case (c)
      2'b00: return 1;
      2'b01: return 8;
      2'b10: return 64;
      default: return 1024;
    endcase
  endfunction

  // one clock: drive, compare, advance the model
  task automatic cyc(input logic s, input logic rw, input logic [4:0] a,
                     input logic [7:0] wd, input logic en, input logic ef,
                     input string tag);
    logic wr, rt, rf;
    int   exp_rd, exp_irq;
    reg_sel = s; rd_wr = rw; addr = a; wdata = wd; clk_en = en; edge_flag = ef;
    #1;
    wr = s & ~rw & a[4] & a[2];
    rt = s &  rw & a[2] & ~a[0];
    rf = s &  rw & a[2] &  a[0];
    exp_rd  = rt ? m_cnt : (rf ? ((m_flag << 7) | (int'(ef) << 6)) : 0);
    exp_irq = ((m_flag && m_ie) || ef) ? 0 : 1;
    vecs++;
    if (int'(rdata) != exp_rd) begin
      fails++;
      $display("FAIL %s rdata act %0h exp %0h at %0t", tag, rdata, exp_rd, $time);
    end
    if (int'(irq_n) != exp_irq) begin
      fails++;
      $display("FAIL %s irq_n act %0d exp %0d at %0t", tag, irq_n, exp_irq, $time);
    end
    if (wr) begin
      m_n = ratio(a[1:0]); m_cnt = wd; m_pre = m_n - 1; m_flag = 0; m_ie = a[3];
    end else if (rt) begin
      m_ie = a[3]; m_flag = 0; m_pre = m_n - 1;
    end else if (en) begin
      if (m_flag || m_pre == 0) begin
        if (!m_flag) m_pre = m_n - 1;
        if (m_cnt == 0) m_flag = 1;
        m_cnt = (m_cnt + 255) % 256;
      end else begin
        m_pre--;
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n, input logic en, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 5'd0, 8'd0, en, 1'b0, tag);
  endtask

  // flag read every cycle: side-effect free, exposes the timeout
  task automatic poll(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b1, 5'b00101, 8'd0, 1'b1, 1'b0, tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, with counting held off
    idle(2, 1'b0, "R1");
    cyc(1'b1, 1'b1, 5'b00100, 8'd0, 1'b0, 1'b0, "R1");
    cyc(1'b1, 1'b1, 5'b00101, 8'd0, 1'b0, 1'b0, "R1");

    // R2 R4: load 5, divide by 1, interrupt enabled
    cyc(1'b1, 1'b0, 5'b11100, 8'd5, 1'b0, 1'b0, "R2");
    cyc(1'b1, 1'b1, 5'b01100, 8'd0, 1'b0, 1'b0, "R2");
    // R7 R8: run through zero, fast decrement with irq low
    poll(12, "R7");
    cyc(1'b1, 1'b1, 5'b01100, 8'd0, 1'b1, 1'b0, "R7");
    // R5: count read with A3=0 clears flag and enable
    cyc(1'b1, 1'b1, 5'b00100, 8'd0, 1'b1, 1'b0, "R5");
    poll(3, "R5");

    // R3: divide by 8
    cyc(1'b1, 1'b0, 5'b10101, 8'd3, 1'b1, 1'b0, "R3");
    for (int k = 0; k < 6; k++) begin
      poll(7, "R3");
      cyc(1'b1, 1'b1, 5'b00110, 8'd0, 1'b0, 1'b0, "R3");
      cyc(1'b0, 1'b0, 5'd0, 8'd0, 1'b1, 1'b0, "R3");
    end
    poll(40, "R3");
    // R3: divide by 64
    cyc(1'b1, 1'b0, 5'b11110, 8'd2, 1'b1, 1'b0, "R3");
    poll(63, "R3");
    cyc(1'b1, 1'b1, 5'b01100, 8'd0, 1'b0, 1'b0, "R3");
    poll(200, "R3");
    // R3: divide by 1024
    cyc(1'b1, 1'b0, 5'b11111, 8'd1, 1'b1, 1'b0, "R3");
    poll(1023, "R3");
    cyc(1'b1, 1'b1, 5'b01100, 8'd0, 1'b0, 1'b0, "R3");
    poll(1100, "R3");

    // R9: clk_en low freezes everything
    cyc(1'b1, 1'b0, 5'b10100, 8'd9, 1'b0, 1'b0, "R9");
    idle(20, 1'b0, "R9");
    cyc(1'b1, 1'b1, 5'b00100, 8'd0, 1'b0, 1'b0, "R9");

    // R10: decoys, then read back through the normal interface
    cyc(1'b0, 1'b0, 5'b11100, 8'd77, 1'b0, 1'b0, "R10");
    cyc(1'b1, 1'b0, 5'b01100, 8'd66, 1'b0, 1'b0, "R10");
    cyc(1'b1, 1'b0, 5'b11000, 8'd55, 1'b0, 1'b0, "R10");
    cyc(1'b1, 1'b1, 5'b01000, 8'd0, 1'b0, 1'b0, "R10");
    cyc(1'b1, 1'b1, 5'b00100, 8'd0, 1'b0, 1'b0, "R10");

    // R6 R8: edge flag drives irq and flag bit 6
    cyc(1'b1, 1'b1, 5'b00101, 8'd0, 1'b0, 1'b1, "R6");
    cyc(1'b0, 1'b0, 5'd0, 8'd0, 1'b0, 1'b1, "R8");
    // R6: flag read leaves timeout set
    cyc(1'b1, 1'b0, 5'b11100, 8'd0, 1'b0, 1'b0, "R6");
    cyc(1'b0, 1'b0, 5'd0, 8'd0, 1'b1, 1'b0, "R6");
    cyc(1'b1, 1'b1, 5'b00101, 8'd0, 1'b1, 1'b0, "R6");
    cyc(1'b1, 1'b1, 5'b00101, 8'd0, 1'b1, 1'b1, "R6");
    cyc(1'b1, 1'b1, 5'b00101, 8'd0, 1'b1, 1'b0, "R6");

    // mixed traffic against the model
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = $urandom % 100;
      cyc(r < 25, $urandom % 2 == 1, 5'($urandom), 8'($urandom % 24),
          $urandom % 4 != 0, $urandom % 16 == 0, "R8");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule